// File: doc/BRIEF.md
# Bus Fault Status Capture Unit

This block keeps the record that a small processor's fault handler reads to learn why a bus access failed. Other logic (the stacking sequencer, the exception controller and the priority arbiter) reports each failure as a one-cycle strobe. The block turns those strobes into sticky flags in an 8-bit status word. It keeps a fault address register together with a flag that says whether the stored address can be trusted.

Imprecise data errors arrive out of step with the instruction stream. The block holds such an error as pending while the running code is more urgent than the bus fault. When the bus fault priority becomes the more urgent of the two, it releases the error with a one-cycle activation pulse. Software reads both registers through a small register port and clears status flags by writing ones to them.

Top module: `bfault_capture`

## Requirements
- R1: After reset the status word, the fault address, the pending flag and the activation pulse are all 0. Status bits 6 and 5 always read as 0.
- R2: A precise data error strobe sets status bit 1 and the address-valid bit 7. It loads the fault address register with the address presented alongside it. All three are visible on the cycle after the strobe.
- R3: An instruction fetch error strobe sets status bit 0. It leaves the fault address and bit 7 as they were.
- R4: A stacking error strobe sets status bit 4. It leaves the fault address and bit 7 as they were.
- R5: An unstacking error strobe sets status bit 3. It leaves the fault address and bit 7 as they were.
- R6: An imprecise error strobe sets status bit 2 and the pending flag on the following cycle. It does not change the fault address.
- R7: A pending imprecise error stays pending, with no activation pulse, while the bus fault priority value is greater than or equal to the execution priority value. A lower value means a more urgent priority. At the first clock edge where pending is set and the bus fault value is strictly lower, pending drops and the activation output is high for the one following cycle.
- R8: A precise error that arrives while an imprecise error is pending makes status bits 2 and 1 read 1 together, and the pending flag stays set.
- R9: A memory-management fault strobe clears bit 7 and leaves the fault address unchanged. If a precise error arrives in the same cycle, the precise error wins and bit 7 is set.
- R10: A register write to select 0 (status) clears each status bit written as 1. Bits written as 0 are unchanged, and writes to the reserved bits have no effect. Writes to select 1 (address) have no effect.
- R11: When a fault event and a software clear hit the same status bit in one cycle, the bit stays set.
- R12: The read data shows the status word, zero-extended, when the select is 0. It shows the fault address, zero-extended, when the select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_precise_i | input | 1 | Precise data bus error strobe |
| ev_precise_addr_i | input | ADDR_W | Address of the failed precise access |
| ev_ifetch_i | input | 1 | Instruction fetch bus error strobe |
| ev_imprecise_i | input | 1 | Imprecise data bus error strobe |
| ev_stack_i | input | 1 | Bus error while stacking on exception entry |
| ev_unstack_i | input | 1 | Bus error while unstacking on exception return |
| ev_mmfault_i | input | 1 | Memory-management fault strobe |
| exec_prio_i | input | PRIO_W | Current execution priority (lower is more urgent) |
| bf_prio_i | input | PRIO_W | Configured bus fault priority |
| reg_addr_i | input | 1 | Register select: 0 status, 1 fault address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data |
| status_o | output | 8 | Status word |
| fault_addr_o | output | ADDR_W | Fault address register |
| imp_pending_o | output | 1 | Imprecise error waiting for activation |
| imp_activate_o | output | 1 | One-cycle pulse when the pending error is released |

## Verification
The properties assume that every event strobe is low while reset is asserted. They also assume that the priority inputs and the register port hold steady values through each clock edge, so that `$past` of an event matches what the block captured. The directed stimulus changes inputs only on the falling clock edge and drops every strobe after a single rising edge. It moves the priorities only between events, so the priority on each side of the hold boundary (equal values, then one lower) is seen in isolation.

// File: rtl/bfault_pkg.sv
package bfault_pkg;
   localparam int STAT_W    = 8;
   localparam int N_FLAGS   = 5;
   localparam int B_IBUS    = 0;
   localparam int B_PREC    = 1;
   localparam int B_IMP     = 2;
   localparam int B_UNSTK   = 3;
   localparam int B_STK     = 4;
   localparam int B_VALID   = 7;

   typedef enum logic [0:0] {
      SEL_STATUS = 1'b0,
      SEL_ADDR   = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/bfault_sticky_bits.sv
module bfault_sticky_bits #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   for (genvar k = 0; k < N; k++) begin : g_cell
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          bit_q <= 1'b0;
         else if (set_i[k])   bit_q <= 1'b1;   // event beats clear
         else if (clr_i[k])   bit_q <= 1'b0;
      end
      assign q_o[k] = bit_q;
   end
endmodule

// File: rtl/bfault_addr_capture.sv
module bfault_addr_capture #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              inval_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o
);
   logic              valid_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (load_i)  addr_q <= addr_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        valid_q <= 1'b0;
      else if (load_i)   valid_q <= 1'b1;
      else if (inval_i)  valid_q <= 1'b0;
   end

   assign valid_o = valid_q;
   assign addr_o  = addr_q;
endmodule

// File: rtl/bfault_imp_tracker.sv
module bfault_imp_tracker #(
   parameter int PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_i,
   input  logic [PRIO_W-1:0] exec_prio_i,
   input  logic [PRIO_W-1:0] bf_prio_i,
   output logic              pending_o,
   output logic              activate_o
);
   logic pend_q;
   logic act_q;
   logic may_run;

   // lower numeric value means more urgent
   assign may_run = bf_prio_i < exec_prio_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         pend_q <= ev_i | (pend_q & ~may_run);
         act_q  <= pend_q & may_run;
      end
   end

   assign pending_o  = pend_q;
   assign activate_o = act_q;
endmodule

// File: rtl/bfault_capture.sv
module bfault_capture
   import bfault_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PRIO_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_precise_i,
   input  logic [ADDR_W-1:0] ev_precise_addr_i,
   input  logic              ev_ifetch_i,
   input  logic              ev_imprecise_i,
   input  logic              ev_stack_i,
   input  logic              ev_unstack_i,
   input  logic              ev_mmfault_i,
   input  logic [PRIO_W-1:0] exec_prio_i,
   input  logic [PRIO_W-1:0] bf_prio_i,
   input  logic              reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic [STAT_W-1:0] status_o,
   output logic [ADDR_W-1:0] fault_addr_o,
   output logic              imp_pending_o,
   output logic              imp_activate_o
);
   localparam int SPAD_W = DATA_W - STAT_W;
   localparam int APAD_W = DATA_W - ADDR_W;

   if (DATA_W < STAT_W)  begin : g_bad_dw   $error("DATA_W must hold the status word"); end
   if (DATA_W < ADDR_W)  begin : g_bad_aw   $error("DATA_W must hold the fault address"); end
   if (ADDR_W < 1)       begin : g_bad_a    $error("ADDR_W must be positive"); end
   if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_p $error("PRIO_W out of range"); end

   reg_sel_e            sel;
   logic [STAT_W-1:0]   sw_clr;
   logic [N_FLAGS-1:0]  flag_set;
   logic [N_FLAGS-1:0]  flags;
   logic                addr_valid;
   logic                wdata_unused;

   assign sel          = reg_sel_e'(reg_addr_i);
   assign sw_clr       = (reg_wr_i && sel == SEL_STATUS) ? reg_wdata_i[STAT_W-1:0] : '0;
   assign wdata_unused = ^reg_wdata_i;

   always_comb begin
      flag_set         = '0;
      flag_set[B_IBUS]  = ev_ifetch_i;
      flag_set[B_PREC]  = ev_precise_i;
      flag_set[B_IMP]   = ev_imprecise_i;
      flag_set[B_UNSTK] = ev_unstack_i;
      flag_set[B_STK]   = ev_stack_i;
   end

   bfault_sticky_bits #(.N(N_FLAGS)) i_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set),
      .clr_i (sw_clr[N_FLAGS-1:0]),
      .q_o   (flags)
   );

   bfault_addr_capture #(.ADDR_W(ADDR_W)) i_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (ev_precise_i),
      .addr_i  (ev_precise_addr_i),
      .inval_i (ev_mmfault_i | sw_clr[B_VALID]),
      .valid_o (addr_valid),
      .addr_o  (fault_addr_o)
   );

   bfault_imp_tracker #(.PRIO_W(PRIO_W)) i_imp (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_i        (ev_imprecise_i),
      .exec_prio_i (exec_prio_i),
      .bf_prio_i   (bf_prio_i),
      .pending_o   (imp_pending_o),
      .activate_o  (imp_activate_o)
   );

   always_comb begin
      status_o                   = '0;
      status_o[N_FLAGS-1:0]      = flags;
      status_o[B_VALID]          = addr_valid;
   end

   logic [DATA_W-1:0] stat_rd;
   logic [DATA_W-1:0] addr_rd;

   if (SPAD_W > 0) begin : g_spad
      assign stat_rd = {{SPAD_W{1'b0}}, status_o};
   end else begin : g_snopad
      assign stat_rd = status_o;
   end

   if (APAD_W > 0) begin : g_apad
      assign addr_rd = {{APAD_W{1'b0}}, fault_addr_o};
   end else begin : g_anopad
      assign addr_rd = fault_addr_o;
   end

   assign reg_rdata_o = (sel == SEL_ADDR) ? addr_rd : stat_rd;
endmodule

// File: rtl/bfault_capture_chk.sv
module bfault_capture_chk #(
   parameter int ADDR_W = 32,
   parameter int PRIO_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_precise_i,
   input logic [ADDR_W-1:0] ev_precise_addr_i,
   input logic              ev_imprecise_i,
   input logic              ev_stack_i,
   input logic              ev_mmfault_i,
   input logic [PRIO_W-1:0] exec_prio_i,
   input logic [PRIO_W-1:0] bf_prio_i,
   input logic              reg_addr_i,
   input logic              reg_wr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic [7:0]        status_o,
   input logic [ADDR_W-1:0] fault_addr_o,
   input logic              imp_pending_o,
   input logic              imp_activate_o
);
   p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[6:5] == 2'b00);

   p_precise_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_precise_i |=> (status_o[7] && status_o[1] &&
                        fault_addr_o == $past(ev_precise_addr_i)));

   // covers R3, R4, R5, R6 and R10: only a precise error moves the address
   p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_precise_i |=> $stable(fault_addr_o));

   p_imp_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_imprecise_i |=> (imp_pending_o && status_o[2]));

   p_activate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (imp_pending_o && bf_prio_i < exec_prio_i && !ev_imprecise_i)
      |=> (!imp_pending_o && imp_activate_o));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (imp_pending_o && !(bf_prio_i < exec_prio_i))
      |=> (imp_pending_o && !imp_activate_o));

   p_both_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_precise_i && imp_pending_o) |=> (status_o[2] && status_o[1]));

   p_mm_inval_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_mmfault_i && !ev_precise_i) |=> !status_o[7]);

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[4] && !(reg_wr_i && !reg_addr_i && reg_wdata_i[4])) |=> status_o[4]);

   p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stack_i |=> status_o[4]);
endmodule

bind bfault_capture bfault_capture_chk #(
   .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
) i_bfault_capture_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .ev_precise_i      (ev_precise_i),
   .ev_precise_addr_i (ev_precise_addr_i),
   .ev_imprecise_i    (ev_imprecise_i),
   .ev_stack_i        (ev_stack_i),
   .ev_mmfault_i      (ev_mmfault_i),
   .exec_prio_i       (exec_prio_i),
   .bf_prio_i         (bf_prio_i),
   .reg_addr_i        (reg_addr_i),
   .reg_wr_i          (reg_wr_i),
   .reg_wdata_i       (reg_wdata_i),
   .status_o          (status_o),
   .fault_addr_o      (fault_addr_o),
   .imp_pending_o     (imp_pending_o),
   .imp_activate_o    (imp_activate_o)
);

// File: tb/test_bfault_capture.sv
module test_bfault_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_precise_i = 1'b0;
   logic [31:0] ev_precise_addr_i = '0;
   logic        ev_ifetch_i = 1'b0;
   logic        ev_imprecise_i = 1'b0;
   logic        ev_stack_i = 1'b0;
   logic        ev_unstack_i = 1'b0;
   logic        ev_mmfault_i = 1'b0;
   logic [7:0]  exec_prio_i = 8'h20;
   logic [7:0]  bf_prio_i = 8'h40;
   logic        reg_addr_i = 1'b0;
   logic        reg_wr_i = 1'b0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic [7:0]  status_o;
   logic [31:0] fault_addr_o;
   logic        imp_pending_o;
   logic        imp_activate_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   bfault_capture i_bfault_capture (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // strobe events for one rising edge; mask bits: 0 ifetch,1 precise,2 imprecise,3 unstack,4 stack,5 mm
   task automatic fire(input logic [5:0] ev, input logic [31:0] addr,
                       input logic wr, input logic [31:0] wdata);
      ev_ifetch_i       = ev[0];
      ev_precise_i      = ev[1];
      ev_imprecise_i    = ev[2];
      ev_unstack_i      = ev[3];
      ev_stack_i        = ev[4];
      ev_mmfault_i      = ev[5];
      ev_precise_addr_i = addr;
      reg_addr_i        = 1'b0;
      reg_wr_i          = wr;
      reg_wdata_i       = wdata;
      @(posedge clk);
      @(negedge clk);
      {ev_ifetch_i, ev_precise_i, ev_imprecise_i, ev_unstack_i, ev_stack_i, ev_mmfault_i} = '0;
      reg_wr_i    = 1'b0;
      reg_wdata_i = '0;
   endtask

   task automatic write_reg(input logic sel, input logic [31:0] d);
      reg_addr_i  = sel;
      reg_wr_i    = 1'b1;
      reg_wdata_i = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr_i    = 1'b0;
      reg_addr_i  = 1'b0;
   endtask

   task automatic read_reg(input logic sel, output logic [31:0] d);
      reg_addr_i = sel;
      #1 d = reg_rdata_o;
      reg_addr_i = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 status", status_o, 32'h0);
      check("R1 addr", fault_addr_o, 32'h0);
      check("R1 pending", imp_pending_o, 32'h0);
      check("R1 activate", imp_activate_o, 32'h0);
      read_reg(1'b0, d);
      check("R12 read status", d, 32'h0);
   endtask

   task automatic t_precise();
      logic [31:0] d;
      fire(6'b000010, 32'hDEAD_BEE0, 1'b0, '0);
      check("R2 status", status_o, 32'h82);
      check("R2 addr", fault_addr_o, 32'hDEAD_BEE0);
      read_reg(1'b1, d);
      check("R12 read addr", d, 32'hDEAD_BEE0);
      read_reg(1'b0, d);
      check("R12 read status", d, 32'h82);
   endtask

   task automatic t_mm();
      fire(6'b100000, 32'h1111_1111, 1'b0, '0);
      check("R9 mm clears valid", status_o, 32'h02);
      check("R9 mm keeps addr", fault_addr_o, 32'hDEAD_BEE0);
      fire(6'b100010, 32'h0000_4440, 1'b0, '0);
      check("R9 precise wins over mm", status_o, 32'h82);
      check("R9 addr loaded", fault_addr_o, 32'h0000_4440);
      write_reg(1'b0, 32'hFFFF_FFFF);
      check("R10 clear all", status_o, 32'h0);
      check("R10 addr kept after clear", fault_addr_o, 32'h0000_4440);
   endtask

   task automatic t_ifetch_stack();
      fire(6'b000001, 32'h5555_0000, 1'b0, '0);
      check("R3 ifetch", status_o, 32'h01);
      check("R3 addr kept", fault_addr_o, 32'h0000_4440);
      fire(6'b010000, 32'h6666_0000, 1'b0, '0);
      check("R4 stack", status_o, 32'h11);
      check("R4 addr kept", fault_addr_o, 32'h0000_4440);
      fire(6'b001000, 32'h7777_0000, 1'b0, '0);
      check("R5 unstack", status_o, 32'h19);
      check("R5 addr kept", fault_addr_o, 32'h0000_4440);
   endtask

   task automatic t_w1c();
      write_reg(1'b0, 32'h0000_0010);
      check("R10 clear bit4 only", status_o, 32'h09);
      write_reg(1'b0, 32'h0000_0000);
      check("R10 zero write no effect", status_o, 32'h09);
      write_reg(1'b0, 32'hFFFF_FF60);
      check("R10 reserved write no effect", status_o, 32'h09);
      write_reg(1'b1, 32'hFFFF_FFFF);
      check("R10 addr write ignored", fault_addr_o, 32'h0000_4440);
      check("R10 addr write leaves status", status_o, 32'h09);
      write_reg(1'b0, 32'h0000_00FF);
      check("R10 clear rest", status_o, 32'h0);
   endtask

   task automatic t_imprecise();
      exec_prio_i = 8'h20;
      bf_prio_i   = 8'h40;
      fire(6'b000100, 32'h9999_0000, 1'b0, '0);
      check("R6 imprecise flag", status_o, 32'h04);
      check("R6 addr kept", fault_addr_o, 32'h0000_4440);
      check("R6 pending", imp_pending_o, 32'h1);
      repeat (3) @(negedge clk);
      check("R7 still pending", imp_pending_o, 32'h1);
      check("R7 no pulse", imp_activate_o, 32'h0);
      fire(6'b000010, 32'hABCD_0000, 1'b0, '0);
      check("R8 both flags", status_o, 32'h86);
      check("R8 pending kept", imp_pending_o, 32'h1);
      bf_prio_i = 8'h20;
      @(negedge clk);
      check("R7 equal holds", imp_pending_o, 32'h1);
      check("R7 equal no pulse", imp_activate_o, 32'h0);
      bf_prio_i = 8'h1F;
      @(negedge clk);
      check("R7 released", imp_pending_o, 32'h0);
      check("R7 pulse", imp_activate_o, 32'h1);
      @(negedge clk);
      check("R7 pulse one cycle", imp_activate_o, 32'h0);
      check("R7 stays released", imp_pending_o, 32'h0);
      bf_prio_i = 8'h40;
      write_reg(1'b0, 32'h0000_00FF);
   endtask

   task automatic t_race();
      fire(6'b010000, 32'h0, 1'b0, '0);
      fire(6'b010000, 32'h0, 1'b1, 32'h0000_0010);
      check("R11 stack beats clear", status_o, 32'h10);
      fire(6'b000010, 32'h0BAD_0000, 1'b1, 32'h0000_0082);
      check("R11 precise beats clear", status_o, 32'h92);
      check("R11 addr", fault_addr_o, 32'h0BAD_0000);
      write_reg(1'b0, 32'h0000_0080);
      check("R10 clear valid only", status_o, 32'h12);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_precise();
      t_mm();
      t_ifetch_stack();
      t_w1c();
      t_imprecise();
      t_race();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule